// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block holds an 8-bit interrupt status word for a hardware monitor. Each cycle, the limit comparators upstream present one violation flag for each of five channels: the local temperature, the two remote temperatures, the core supply and the main supply. A flag that is high sets its status bit, and the bit stays set after the flag drops. Software then has a record of every excursion, including ones that lasted a single cycle.

A read strobe from the bus logic does two things. In the same cycle, it returns the held value. It also clears every held bit whose fault is absent in that cycle, and the clear takes effect on the next cycle. A bit whose fault is still present in the read cycle stays set, so a read never hides a fault that is still active.

The top bit is not stored. It is a live OR of a second 8-bit status word, so one read shows whether anything is pending there. An interrupt line is high while any held bit or the summary bit is set.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, every held bit is 0. With the second status word at zero, `rd_data` reads 0x00 and `irq` is low.
- R2: Temperature faults set their bits on the clock edge that samples the flag, so the bit is visible from the next cycle. The mapping is remote 1 to bit 4, local to bit 5, and remote 2 to bit 6.
- R3: Supply faults set their bits on the clock edge that samples the flag, so the bit is visible from the next cycle. The mapping is core supply to bit 1 and main supply to bit 2.
- R4: A held bit stays 1 after its flag returns low, as long as no read occurs.
- R5: In a read cycle, `rd_data` shows the value held before the read. Each held bit whose flag is low in that cycle reads 0 from the next cycle.
- R6: If a bit's flag is high in a read cycle, the set wins and the bit stays 1.
- R7: Bit 7 of `rd_data` equals the OR of all eight bits of `status2` in the same cycle. It is not stored and reads do not change it.
- R8: Bits 0 and 3 of `rd_data` always read 0.
- R9: `irq` equals the OR of all bits of `rd_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_fault | input | 1 | Local temperature outside its limits this cycle |
| rem1_fault | input | 1 | Remote 1 temperature outside its limits this cycle |
| rem2_fault | input | 1 | Remote 2 temperature outside its limits this cycle |
| vcore_fault | input | 1 | Core supply outside its limits this cycle |
| vmain_fault | input | 1 | Main supply outside its limits this cycle |
| status2 | input | 8 | Contents of the second status register |
| rd_stb | input | 1 | One-cycle read strobe for this register |
| rd_data | output | 8 | Current register value |
| irq | output | 1 | High while any status bit is set |

## Verification
The bench targets the following corner cases:
- **Read while the fault is still present.** A design that clears unconditionally would drop that bit.
- **Read in the cycle the fault disappears.** A design that compares against a delayed flag would keep the bit for one read too many.
- **Data returned by the read itself.** A design that clears before driving the data would return zeros.
- **Summary bit after a read.** This bit must not be latched, so it must track `status2` straight through a read. A stored copy would either linger or lag by a cycle.
- **Reserved bits and interrupt line.** These are checked on every random cycle.

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_fault,
  input  logic             rem1_fault,
  input  logic             rem2_fault,
  input  logic             vcore_fault,
  input  logic             vmain_fault,
  input  logic [SUM_W-1:0] status2,
  input  logic             rd_stb,
  output logic [7:0]       rd_data,
  output logic             irq
);

  localparam int B_VCORE = 1;
  localparam int B_VMAIN = 2;
  localparam int B_REM1  = 4;
  localparam int B_LOC   = 5;
  localparam int B_REM2  = 6;
  localparam int B_SUM   = 7;

  logic [7:0] cond;
  logic [7:0] held;
  logic [7:0] held_nxt;
  logic       summary;

  always_comb begin
    cond          = '0;
    cond[B_VCORE] = vcore_fault;
    cond[B_VMAIN] = vmain_fault;
    cond[B_REM1]  = rem1_fault;
    cond[B_LOC]   = loc_fault;
    cond[B_REM2]  = rem2_fault;
  end

  // a read drops a held bit only where its fault is absent; a present fault sets
  assign held_nxt = cond | (rd_stb ? 8'h00 : held);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= '0;
    else        held <= held_nxt;

  assign summary = |status2;

  always_comb begin
    rd_data        = held;
    rd_data[B_SUM] = summary;
  end

  assign irq = |held | summary;

endmodule

module irq_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loc_fault,
  input logic       rem1_fault,
  input logic       vcore_fault,
  input logic       vmain_fault,
  input logic [7:0] status2,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic       irq
);

  // R2
  loc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_fault |=> rd_data[5]);

  // R3
  vcore_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcore_fault |=> rd_data[1]);

  // R4
  hold_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && rd_data[6]) |=> rd_data[6]);

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !vmain_fault) |=> !rd_data[2]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rem1_fault) |=> rd_data[4]);

  // R7
  summary_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == (|status2));

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|rd_data));

endmodule

bind irq_status_reg irq_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .loc_fault(loc_fault), .rem1_fault(rem1_fault),
  .vcore_fault(vcore_fault), .vmain_fault(vmain_fault), .status2(status2),
  .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       loc_fault = 0, rem1_fault = 0, rem2_fault = 0;
  logic       vcore_fault = 0, vmain_fault = 0;
  logic [7:0] status2 = 0;
  logic       rd_stb = 0;
  logic [7:0] rd_data;
  logic       irq;

  int vecs = 0, errs = 0;
  logic [7:0] m_held = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_reg dut (.*);

  function automatic logic [7:0] cond_vec();
    return {1'b0, rem2_fault, loc_fault, rem1_fault, 1'b0, vmain_fault, vcore_fault, 1'b0};
  endfunction

  function automatic logic [7:0] exp_data();
    logic [7:0] d = m_held;
    d[7] = |status2;
    return d;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] e = exp_data();
    chk("R2", {5'd0, rd_data[6:4]}, {5'd0, e[6:4]});
    chk("R3", {6'd0, rd_data[2:1]}, {6'd0, e[2:1]});
    chk("R7", {7'd0, rd_data[7]}, {7'd0, e[7]});
    chk("R8", {6'd0, rd_data[3], rd_data[0]}, 8'd0);
    chk("R9", {7'd0, irq}, {7'd0, |e});
  endtask

  task automatic step(logic l, logic r1, logic r2, logic vc, logic vm, logic [7:0] s2, logic rd);
    @(negedge clk);
    loc_fault = l; rem1_fault = r1; rem2_fault = r2;
    vcore_fault = vc; vmain_fault = vm; status2 = s2; rd_stb = rd;
    #2 check_all();
    @(posedge clk);
    m_held = cond_vec() | (rd ? 8'h00 : m_held);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    #35;
    chk("R1", rd_data, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);
    rst_n = 1;

    // R2 R4: set local and remote 2, drop flags, no read
    step(1, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #2 chk("R4", rd_data, 8'h60);
    // R5: read returns old value, clears next cycle
    step(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk); #2 chk("R5", rd_data, 8'h00);
    // R6: read with condition present keeps bit
    step(0, 1, 0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    @(negedge clk); #2 chk("R6", rd_data, 8'h10);
    step(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk); #2 chk("R5", rd_data, 8'h00);
    // R7: summary live through read
    step(0, 0, 0, 0, 0, 8'h40, 1);
    step(0, 0, 0, 0, 0, 8'h40, 1);
    step(0, 0, 0, 0, 0, 8'h00, 0);
    @(negedge clk); #2 chk("R7", rd_data, 8'h00);
    // R3: supplies
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #2 chk("R3", rd_data, 8'h06);

    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
           ($urandom % 5) == 0, ($urandom % 5) == 0,
           (($urandom % 4) == 0) ? 8'($urandom) : 8'h00, ($urandom % 3) == 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule